// File: doc/BRIEF.md
# Extended-Precision Power-of-Two Scaler

This unit multiplies a 96-bit container holding an extended-precision floating-point value by two raised to a signed integer. The work is done on the bit fields directly. The integer is added to the biased exponent. Results that land below the exponent range are shifted right and rounded under one of four modes. Unnormalized mantissas are pulled left before a result is declared too large.

Special destinations (zero, infinity, quiet and signaling NaN) and a NaN scale operand bypass the arithmetic. Each of these bypass cases produces a fixed result and sets fixed flags. The surrounding floating-point pipeline hands over the following items together with a one-cycle `inValid` strobe:

- an operand that has already been converted to an integer;
- its source width;
- a class tag for that operand;
- the rounding mode;
- the trap-enable mask.

One clock later it collects the result, seven status flags and a trap request.

Top module: `xp_scale`

## Requirements
- R1: The value is packed with the sign in bit 95, a 15-bit biased exponent in bits 94:80 and a 64-bit mantissa with an explicit integer bit in bits 63:0. Bits 79:64 of every result are zero.
- R2: `scaleWidth` selects the operand width. 0 takes bits 7:0 and sign-extends them. 1 takes bits 15:0 and sign-extends them. 2 and 3 use all 32 bits.
- R3: For a finite, nonzero destination (exponent below 0x7FFF), the new exponent is the old exponent plus the scale. When that sum lies in 1..0x7FFE and mantissa bit 63 is set, the mantissa passes through unchanged.
- R4: If an in-range sum has mantissa bit 63 clear, the mantissa is shifted left and the exponent is decremented once per step. Shifting stops when bit 63 is set or the exponent reaches 0, and a result still unnormalized at exponent 0 stays a denormal.
- R5: A sum of 0 or below gives exponent 0, with the mantissa shifted right by minus the sum and rounded from the guard, round and sticky bits. `roundMode` selects the rounding: 0 is to nearest with ties to even, 1 is toward zero, 2 is toward minus infinity and 3 is toward plus infinity.
- R6: A right shift of 66 or more leaves no kept bits. The whole mantissa then only feeds the sticky bit, so the result mantissa is 0 or 1.
- R7: A sum of 0x7FFF or more first renormalizes the mantissa leftwards, decrementing the exponent. If the exponent is still 0x7FFF or more, the result is infinity (exponent 0x7FFF, mantissa 0) and the overflow flag is raised.
- R8: A zero destination and an infinite destination (exponent 0x7FFF, mantissa 0) are returned unchanged.
- R9: A destination with exponent 0x7FFF, a nonzero mantissa and bit 62 clear is a signaling NaN. It is returned with bit 62 set and raises the signaling-NaN flag. A destination with exponent 0x7FFF and bit 62 set passes unchanged.
- R10: `scaleClass` 2 or 3 (NaN operand) gives exponent 0x7FFF and an all-ones mantissa, keeps the destination sign, and raises operand-error. `scaleClass` 1 (zero operand) returns the destination unchanged and raises no exception flag.
- R11: `statusFlags` bits are: [0] overflow, [1] infinity, [2] NaN, [3] signaling NaN, [4] operand error, [5] zero and [6] negative. Bits 1, 2, 5 and 6 are derived from the result. Bits 0, 3 and 4 are recomputed afresh for every operation.
- R12: `excReq` is high when any of overflow, signaling NaN or operand error is raised together with its enable. `excEnable` bit 0 enables overflow, bit 1 enables signaling NaN and bit 2 enables operand error.
- R13: Outputs update on the clock edge after `inValid`, and `outValid` is high for exactly that cycle. Without `inValid` the outputs hold. After reset the result is 0, `statusFlags` is 7'b0100000 and `excReq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Start of an operation |
| dstVal | input | 96 | Destination value |
| scaleRaw | input | 32 | Integer scale operand |
| scaleWidth | input | 2 | Source width of the scale |
| scaleClass | input | 2 | Scale class: 0 number, 1 zero, 2/3 NaN |
| roundMode | input | 2 | Rounding mode |
| excEnable | input | 3 | Trap enables |
| outValid | output | 1 | Result valid |
| resVal | output | 96 | Scaled value |
| statusFlags | output | 7 | Exception and condition flags |
| excReq | output | 1 | Trap request |

## Verification
Renormalization and overflow detection meet in one operation when an unnormalized mantissa is paired with an exponent sum just above the top of the range. Vectors sit on both sides of the point where the leading-zero count exactly pulls the exponent back to 0x7FFE. One side must give a normalized finite value and the other must give infinity with the overflow flag. Denormalizing and rounding also fall together. Halfway, above-half and saturated shifts are run under all four modes and both signs, and every result is judged against an independent bit-serial reference model in the bench.

// File: rtl/xp_scale_pkg.sv
package xp_scale_pkg;
  localparam int MAN_W   = 64;
  localparam int EXP_W   = 15;
  localparam int PAD_W   = 16;
  localparam int SCALE_W = 32;
  localparam int VAL_W   = 1 + EXP_W + PAD_W + MAN_W;
  localparam int SUM_W   = SCALE_W + 2;
  localparam int SH_MAX  = MAN_W + 2;
  localparam int SH_W    = $clog2(SH_MAX + 1);
  localparam int LZ_W    = $clog2(MAN_W + 1);
  localparam int EXC_W   = 3;
  localparam int FLAG_W  = 7;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] expo;
    logic [PAD_W-1:0] pad;
    logic [MAN_W-1:0] man;
  } xpVal_t;

  typedef enum logic [1:0] {SEL_PASS, SEL_ARITH, SEL_QUIET, SEL_DNAN} resSel_e;

  typedef struct packed {
    logic    load;
    resSel_e sel;
  } dpStrobe_t;

  typedef struct packed {
    logic neg;
    logic zero;
    logic operr;
    logic snan;
    logic nan;
    logic inf;
    logic ovfl;
  } flags_t;
endpackage

// File: rtl/xp_scale_lzc.sv
module xp_scale_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  // Highest set bit wins because it is visited last.
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/xp_scale_denorm.sv
module xp_scale_denorm #(
  parameter int W   = 64,
  parameter int SHW = $clog2(W + 3)
) (
  input  logic [W-1:0]   manIn,
  input  logic [SHW-1:0] shAmt,
  input  logic           sgn,
  input  logic [1:0]     roundMode,
  output logic [W-1:0]   manOut
);
  localparam int EXT_W = 2 * W + 2;

  logic [EXT_W-1:0] ext;
  logic guardB, roundB, stickyB, inexact, incr;

  // Two extra low positions hold guard and round even at the saturated shift.
  always_comb begin
    ext     = {manIn, {(W + 2){1'b0}}} >> shAmt;
    guardB  = ext[W+1];
    roundB  = ext[W];
    stickyB = |ext[W-1:0];
    inexact = guardB | roundB | stickyB;
    unique case (roundMode)
      2'd0:    incr = guardB & (roundB | stickyB | ext[W+2]);
      2'd1:    incr = 1'b0;
      2'd2:    incr = inexact & sgn;
      default: incr = inexact & ~sgn;
    endcase
    manOut = ext[EXT_W-1 -: W] + W'(incr);
  end
endmodule

// File: rtl/xp_scale_dp.sv
module xp_scale_dp
  import xp_scale_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  xpVal_t             dst,
  input  logic [SCALE_W-1:0] scaleRaw,
  input  logic [1:0]         scaleWidth,
  input  logic [1:0]         roundMode,
  output logic               arithOvf,
  output xpVal_t             res
);
  localparam logic signed [SUM_W-1:0] TOP_S   = {{(SUM_W-EXP_W){1'b0}}, EXP_MAX};
  localparam logic signed [SUM_W-1:0] SAT_NEG = -SUM_W'(SH_MAX);

  logic [SCALE_W-1:0]      scaleExt;
  logic signed [SUM_W-1:0] sumExp, negExp, normExp, lzExt;
  logic [LZ_W-1:0]         lzCount, rangeSh;
  logic [SH_W-1:0]         shSat;
  logic [MAN_W-1:0]        manDen;
  xpVal_t                  arithVal, nextVal;

  always_comb begin
    unique case (scaleWidth)
      2'd0:    scaleExt = {{(SCALE_W-8){scaleRaw[7]}}, scaleRaw[7:0]};
      2'd1:    scaleExt = {{(SCALE_W-16){scaleRaw[15]}}, scaleRaw[15:0]};
      default: scaleExt = scaleRaw;
    endcase
  end

  assign sumExp = $signed({{(SUM_W-EXP_W){1'b0}}, dst.expo})
                + $signed({{(SUM_W-SCALE_W){scaleExt[SCALE_W-1]}}, scaleExt});
  assign negExp = -sumExp;
  assign shSat  = (negExp > SUM_W'(SH_MAX)) ? SH_W'(SH_MAX) : negExp[SH_W-1:0];
  assign lzExt  = $signed({{(SUM_W-LZ_W){1'b0}}, lzCount});

  xp_scale_lzc #(.W(MAN_W), .CW(LZ_W)) lzc_i (
    .vec   (dst.man),
    .count (lzCount)
  );

  xp_scale_denorm #(.W(MAN_W), .SHW(SH_W)) denorm_i (
    .manIn     (dst.man),
    .shAmt     (shSat),
    .sgn       (dst.sgn),
    .roundMode (roundMode),
    .manOut    (manDen)
  );

  always_comb begin
    arithOvf     = 1'b0;
    rangeSh      = '0;
    normExp      = sumExp;
    arithVal.sgn = dst.sgn;
    arithVal.pad = '0;
    arithVal.expo = '0;
    arithVal.man  = manDen;
    if (sumExp <= 0) begin
      arithVal.expo = '0;
      arithVal.man  = manDen;
    end else if (sumExp >= TOP_S) begin
      normExp = sumExp - lzExt;
      if (normExp >= TOP_S) begin
        arithOvf      = 1'b1;
        arithVal.expo = EXP_MAX;
        arithVal.man  = '0;
      end else begin
        arithVal.expo = normExp[EXP_W-1:0];
        arithVal.man  = dst.man << lzCount;
      end
    end else begin
      rangeSh       = (lzExt > sumExp) ? sumExp[LZ_W-1:0] : lzCount;
      normExp       = sumExp - $signed({{(SUM_W-LZ_W){1'b0}}, rangeSh});
      arithVal.expo = normExp[EXP_W-1:0];
      arithVal.man  = dst.man << rangeSh;
    end
  end

  always_comb begin
    nextVal     = dst;
    nextVal.pad = '0;
    unique case (strobe.sel)
      SEL_PASS:  ;
      SEL_ARITH: nextVal = arithVal;
      SEL_QUIET: nextVal.man[MAN_W-2] = 1'b1;
      SEL_DNAN: begin
        nextVal.expo = EXP_MAX;
        nextVal.man  = '1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            res <= '0;
    else if (strobe.load) res <= nextVal;
  end

  // R6: saturated shift leaves at most the rounding increment
  p_sat_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.sel == SEL_ARITH && sumExp <= SAT_NEG)
      |=> (res.expo == '0 && res.man <= 64'd1));

  // R3: normalized in-range mantissa passes untouched
  p_norm_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.sel == SEL_ARITH && sumExp > 0 && sumExp < TOP_S && dst.man[MAN_W-1])
      |=> (res.man == $past(dst.man)));
endmodule

// File: rtl/xp_scale_ctrl.sv
module xp_scale_ctrl
  import xp_scale_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [EXP_W-1:0] dstExp,
  input  logic [MAN_W-1:0] dstMan,
  input  logic [1:0]       scaleClass,
  input  logic [EXC_W-1:0] excEnable,
  input  logic             arithOvf,
  input  logic             resSgn,
  input  logic [EXP_W-1:0] resExp,
  input  logic [MAN_W-1:0] resMan,
  output dpStrobe_t        strobe,
  output logic             outValid,
  output flags_t           flags,
  output logic             excReq
);
  logic dstZero, dstTop;
  logic ovfEv, snanEv, operrEv;
  logic [EXC_W-1:0] excNow, excR;

  assign dstZero = (dstExp == '0) && (dstMan == '0);
  assign dstTop  = (dstExp == EXP_MAX);

  always_comb begin
    strobe.load = inValid;
    strobe.sel  = SEL_ARITH;
    snanEv      = 1'b0;
    operrEv     = 1'b0;
    if (scaleClass[1]) begin
      strobe.sel = SEL_DNAN;
      operrEv    = 1'b1;
    end else if (scaleClass[0] || dstZero) begin
      strobe.sel = SEL_PASS;
    end else if (dstTop) begin
      if (dstMan != '0 && !dstMan[MAN_W-2]) begin
        strobe.sel = SEL_QUIET;
        snanEv     = 1'b1;
      end else begin
        strobe.sel = SEL_PASS;
      end
    end
    ovfEv  = (strobe.sel == SEL_ARITH) && arithOvf;
    excNow = {operrEv, snanEv, ovfEv};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      excR     <= '0;
      excReq   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        excR   <= excNow;
        excReq <= |(excNow & excEnable);
      end
    end
  end

  always_comb begin
    flags.ovfl  = excR[0];
    flags.snan  = excR[1];
    flags.operr = excR[2];
    flags.inf   = (resExp == EXP_MAX) && (resMan == '0);
    flags.nan   = (resExp == EXP_MAX) && (resMan != '0);
    flags.zero  = (resExp == '0) && (resMan == '0);
    flags.neg   = resSgn;
  end

  p_valid_r13: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid);
  p_idle_r13:  assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid);
  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flags.ovfl) |-> (flags.inf && !flags.nan));
  p_dnan_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flags.operr) |-> (resMan == '1 && flags.nan));
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flags.snan) |-> (resMan[MAN_W-2] && flags.nan));
  p_no_trap_r12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && excEnable == '0) |=> !excReq);
  p_zero_clean_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && scaleClass == 2'd1) |=> !(flags.ovfl || flags.snan || flags.operr));
endmodule

// File: rtl/xp_scale.sv
module xp_scale
  import xp_scale_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [VAL_W-1:0]   dstVal,
  input  logic [SCALE_W-1:0] scaleRaw,
  input  logic [1:0]         scaleWidth,
  input  logic [1:0]         scaleClass,
  input  logic [1:0]         roundMode,
  input  logic [EXC_W-1:0]   excEnable,
  output logic               outValid,
  output logic [VAL_W-1:0]   resVal,
  output logic [FLAG_W-1:0]  statusFlags,
  output logic               excReq
);
  xpVal_t    dst, res;
  dpStrobe_t strobe;
  flags_t    flags;
  logic      arithOvf;

  assign dst         = dstVal;
  assign resVal      = res;
  assign statusFlags = flags;

  xp_scale_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .dstExp     (dst.expo),
    .dstMan     (dst.man),
    .scaleClass (scaleClass),
    .excEnable  (excEnable),
    .arithOvf   (arithOvf),
    .resSgn     (res.sgn),
    .resExp     (res.expo),
    .resMan     (res.man),
    .strobe     (strobe),
    .outValid   (outValid),
    .flags      (flags),
    .excReq     (excReq)
  );

  xp_scale_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dst        (dst),
    .scaleRaw   (scaleRaw),
    .scaleWidth (scaleWidth),
    .roundMode  (roundMode),
    .arithOvf   (arithOvf),
    .res        (res)
  );

  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (res.pad == '0));
endmodule

// File: tb/xp_scale_tb_top.sv
`timescale 1ns/1ps
module xp_scale_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [95:0] dstVal = '0;
  logic [31:0] scaleRaw = '0;
  logic [1:0]  scaleWidth = '0;
  logic [1:0]  scaleClass = '0;
  logic [1:0]  roundMode = '0;
  logic [2:0]  excEnable = '0;
  logic        outValid;
  logic [95:0] resVal;
  logic [6:0]  statusFlags;
  logic        excReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xp_scale dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dstVal(dstVal),
    .scaleRaw(scaleRaw), .scaleWidth(scaleWidth), .scaleClass(scaleClass),
    .roundMode(roundMode), .excEnable(excEnable), .outValid(outValid),
    .resVal(resVal), .statusFlags(statusFlags), .excReq(excReq)
  );

  function automatic logic [95:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, 16'h0, m};
  endfunction

  // Bit-serial reference built from the requirements.
  function automatic void refModel(input logic [95:0] d, input logic [31:0] raw,
      input logic [1:0] w, input logic [1:0] cls, input logic [1:0] rm, input logic [2:0] en,
      output logic [95:0] r, output logic [6:0] f, output logic x);
    logic s, g, rb, st, inc;
    longint e, sc, sh;
    logic [63:0] m;
    bit ov, sn, op;
    s = d[95]; e = longint'(d[94:80]); m = d[63:0];
    ov = 0; sn = 0; op = 0;
    case (w)
      2'd0:    sc = longint'($signed(raw[7:0]));
      2'd1:    sc = longint'($signed(raw[15:0]));
      default: sc = longint'($signed(raw));
    endcase
    if (cls >= 2) begin
      e = 32767; m = '1; op = 1;
    end else if (cls == 1) begin
    end else if (e == 0 && m == 0) begin
    end else if (e == 32767) begin
      if (m != 0 && !m[62]) begin m[62] = 1'b1; sn = 1; end
    end else begin
      e = e + sc;
      if (e <= 0) begin
        g = 0; rb = 0; st = 0; sh = -e;
        for (int k = 0; k < 80; k++) begin
          if (longint'(k) < sh) begin
            st = st | rb; rb = g; g = m[0]; m = m >> 1;
          end
        end
        case (rm)
          2'd0: inc = g & (rb | st | m[0]);
          2'd1: inc = 1'b0;
          2'd2: inc = (g | rb | st) & s;
          default: inc = (g | rb | st) & ~s;
        endcase
        m = m + 64'(inc);
        e = 0;
      end else if (e >= 32767) begin
        while (m != 0 && !m[63]) begin m = m << 1; e = e - 1; end
        if (e >= 32767) begin e = 32767; m = '0; ov = 1; end
      end else begin
        while (e > 0 && !m[63]) begin m = m << 1; e = e - 1; end
      end
    end
    r = {s, e[14:0], 16'h0, m};
    f = {s, (e == 0 && m == 0), op, sn, (e == 32767 && m != 0), (e == 32767 && m == 0), ov};
    x = |({op, sn, ov} & en);
  endfunction

  task automatic checkVal(input string tag, input string what, input logic [95:0] act, input logic [95:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic applyOp(input string tag, input logic [95:0] d, input logic [31:0] raw,
      input logic [1:0] w, input logic [1:0] cls, input logic [1:0] rm, input logic [2:0] en);
    logic [95:0] er; logic [6:0] ef; logic ex;
    refModel(d, raw, w, cls, rm, en, er, ef, ex);
    @(negedge clk);
    dstVal = d; scaleRaw = raw; scaleWidth = w; scaleClass = cls;
    roundMode = rm; excEnable = en; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkVal(tag, "result", resVal, er);
    checkVal(tag, "flags", 96'(statusFlags), 96'(ef));
    checkVal(tag, "excReq", 96'(excReq), 96'(ex));
    checkVal("R13", "outValid high", 96'(outValid), 96'd1);
  endtask

  task automatic tReset();
    checkVal("R13", "reset outValid", 96'(outValid), 96'd0);
    checkVal("R13", "reset result", resVal, 96'd0);
    checkVal("R13", "reset flags", 96'(statusFlags), 96'h20);
    checkVal("R13", "reset excReq", 96'(excReq), 96'd0);
  endtask

  task automatic tNormal();
    applyOp("R3", mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 32'd5, 2'd2, 2'd0, 2'd0, 3'd0);
    applyOp("R3", mk(1, 15'h3FFF, 64'hC000_0000_1234_5678), -32'sd10, 2'd2, 2'd0, 2'd0, 3'd7);
    applyOp("R1", {1'b0, 15'h4000, 16'hBEEF, 64'h9000_0000_0000_0001}, 32'd3, 2'd2, 2'd0, 2'd0, 3'd0);
  endtask

  task automatic tWidths();
    applyOp("R2", mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 32'h0000_12F0, 2'd0, 2'd0, 2'd0, 3'd0);
    applyOp("R2", mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 32'hABCD_FFFE, 2'd1, 2'd0, 2'd0, 3'd0);
    applyOp("R2", mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), 32'hFFFF_FF7F, 2'd0, 2'd0, 2'd0, 3'd0);
    applyOp("R2", mk(0, 15'h0100, 64'h8000_0000_0000_0000), 32'h0001_0005, 2'd3, 2'd0, 2'd0, 3'd0);
  endtask

  task automatic tRenorm();
    applyOp("R4", mk(0, 15'h0000, 64'h0000_0000_0001_0000), 32'd100, 2'd2, 2'd0, 2'd0, 3'd0);
    applyOp("R4", mk(0, 15'h0001, 64'h0000_0000_0000_00FF), 32'd2, 2'd2, 2'd0, 2'd0, 3'd0);
    applyOp("R4", mk(1, 15'h0010, 64'h0F00_0000_0000_0000), 32'd0, 2'd2, 2'd0, 2'd0, 3'd0);
  endtask

  task automatic tUnderflow();
    for (int rm = 0; rm < 4; rm++) begin
      for (int s = 0; s < 2; s++) begin
        applyOp("R5", mk(s[0], 15'd5, 64'h8000_0000_0000_0003), -32'sd7, 2'd2, 2'd0, rm[1:0], 3'd0);
        applyOp("R5", mk(s[0], 15'd5, 64'h8000_0000_0000_0006), -32'sd7, 2'd2, 2'd0, rm[1:0], 3'd0);
        applyOp("R5", mk(s[0], 15'd5, 64'h8000_0000_0000_0002), -32'sd7, 2'd2, 2'd0, rm[1:0], 3'd0);
        applyOp("R6", mk(s[0], 15'd1, 64'hFFFF_FFFF_FFFF_FFFF), -32'sd100, 2'd2, 2'd0, rm[1:0], 3'd0);
        applyOp("R6", mk(s[0], 15'd1, 64'h8000_0000_0000_0000), -32'sd66, 2'd2, 2'd0, rm[1:0], 3'd0);
        applyOp("R6", mk(s[0], 15'd1, 64'hC000_0000_0000_0000), -32'sd65, 2'd2, 2'd0, rm[1:0], 3'd0);
      end
    end
    applyOp("R6", mk(0, 15'h4000, 64'h8000_0000_0000_0000), 32'h8000_0000, 2'd2, 2'd0, 2'd3, 3'd0);
  endtask

  task automatic tOverflow();
    applyOp("R7", mk(0, 15'h7FF0, 64'h8000_0000_0000_0000), 32'd100, 2'd2, 2'd0, 2'd0, 3'd1);
    applyOp("R7", mk(1, 15'h7FF0, 64'h0000_0001_0000_0000), 32'd45, 2'd2, 2'd0, 2'd0, 3'd1);
    applyOp("R7", mk(1, 15'h7FF0, 64'h0000_0001_0000_0000), 32'd46, 2'd2, 2'd0, 2'd0, 3'd1);
    applyOp("R12", mk(0, 15'h7FF0, 64'h8000_0000_0000_0000), 32'd100, 2'd2, 2'd0, 2'd0, 3'd6);
  endtask

  task automatic tSpecials();
    applyOp("R8", mk(1, 15'h0000, 64'h0), 32'd77, 2'd2, 2'd0, 2'd0, 3'd7);
    applyOp("R8", mk(0, 15'h7FFF, 64'h0), -32'sd5, 2'd2, 2'd0, 2'd0, 3'd7);
    applyOp("R9", mk(1, 15'h7FFF, 64'h8000_0000_0000_1234), 32'd1, 2'd2, 2'd0, 2'd0, 3'd2);
    applyOp("R9", mk(0, 15'h7FFF, 64'hC000_0000_0000_0001), 32'd1, 2'd2, 2'd0, 2'd0, 3'd7);
    applyOp("R12", mk(1, 15'h7FFF, 64'h8000_0000_0000_1234), 32'd1, 2'd2, 2'd0, 2'd0, 3'd5);
  endtask

  task automatic tScaleClass();
    applyOp("R10", mk(1, 15'h3FFF, 64'h8000_0000_0000_0000), 32'd3, 2'd2, 2'd2, 2'd0, 3'd4);
    applyOp("R10", mk(0, 15'h7FFF, 64'h0), 32'd3, 2'd2, 2'd3, 2'd0, 3'd3);
    applyOp("R10", {1'b1, 15'h2000, 16'h1234, 64'h8765_4321_0000_0000}, 32'd50, 2'd2, 2'd1, 2'd0, 3'd7);
    applyOp("R11", mk(1, 15'h0003, 64'h8000_0000_0000_0000), -32'sd200, 2'd2, 2'd0, 2'd1, 3'd7);
  endtask

  task automatic tHold();
    logic [95:0] held;
    applyOp("R13", mk(0, 15'h1234, 64'hF000_0000_0000_0000), 32'd1, 2'd2, 2'd0, 2'd0, 3'd0);
    held = resVal;
    dstVal = mk(1, 15'h0AAA, 64'h8000_0000_0000_0000);
    scaleRaw = 32'd9;
    repeat (3) @(negedge clk);
    checkVal("R13", "outValid low when idle", 96'(outValid), 96'd0);
    checkVal("R13", "result held when idle", resVal, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tNormal();
    tWidths();
    tRenorm();
    tUnderflow();
    tOverflow();
    tSpecials();
    tScaleClass();
    tHold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule